// File: doc/BRIEF.md
# Bus-Master Retry and Abort Monitor

This block supervises the transactions that a bus-master engine launches. After the engine signals the address phase of a transfer, the block samples the target-claim input (DEVSEL) over a fixed window. If no target claims the cycle inside that window, the block declares a master abort and raises a sticky flag that software clears. Once a target has claimed the cycle, the block counts target retries for the current transfer. It compares that count with a 4-bit programmable limit. When the count first passes the limit, the block fires a one-clock active-low system-error pulse, so the engine stops retrying instead of retrying without end. The same pulse reports the case where the device claims its own master cycle.

A separate timer acts on the bus grant. On each new grant it holds a request output high long enough for one 48-byte cell to move as 32-bit words. This keeps the whole cell inside one bus tenure.

The control FSM has three states. `MS_IDLE` waits for a start. `MS_SEEK` samples DEVSEL inside the claim window. `MS_CLAIMED` waits for the transfer result. The transitions are:

| Transition | From | To | Taken when |
|---|---|---|---|
| *launch* | `MS_IDLE` | `MS_SEEK` | `xfer_start` is high |
| *claim* | `MS_SEEK` | `MS_CLAIMED` | `devsel_seen` is high |
| *timeout* | `MS_SEEK` | `MS_IDLE` | the last window sample passes with no claim |
| *retried* | `MS_CLAIMED` | `MS_IDLE` | `tgt_retry` is high |
| *finished* | `MS_CLAIMED` | `MS_IDLE` | `xfer_done` is high |

Top module: `busmon_top`

## Requirements
- R1: After reset, `serr_n` is 1, `abort_flag` is 0 and `hold_req` is 0.
- R2: After a `xfer_start` clock, `devsel_seen` is sampled on each of the next 4 clocks. A claim on any of these clocks, including the 4th, moves the FSM to `MS_CLAIMED` and sets no abort.
- R3: If none of the 4 window samples shows `devsel_seen`, the FSM returns to `MS_IDLE`. `abort_flag` reads 1 after the clock edge of the 4th sample.
- R4: `abort_flag` stays at 1 until `err_clear` is sampled high. It reads 0 after that clock edge.
- R5: Each `tgt_retry` sampled in `MS_CLAIMED` adds one to the retry count. The count is compared with `retry_limit`, which ranges from 0 to 15. The clock edge at which the count goes from at or below the limit to above it drives `serr_n` to 0 for exactly one clock. With limit 15, the 16th retry fires. With limit 0, the 1st retry fires.
- R6: A `xfer_done` sampled in `MS_CLAIMED` clears the retry count. A later transfer then needs limit+1 fresh retries before `serr_n` pulses.
- R7: The retry count saturates at 31 and does not wrap. Without a completion, any number of further retries gives no second `serr_n` pulse.
- R8: If `devsel_seen` and `self_sel` are high together on a window sample in `MS_SEEK`, `serr_n` is 0 for one clock after that edge.
- R9: A rising edge of `gnt` makes `hold_req` read 1 after that edge for exactly 12 clocks (48 bytes / 4). It then reads 0, even if `gnt` stays high.
- R10: `tgt_retry` and `xfer_done` have no effect outside `MS_CLAIMED`. For example, a retry while idle gives no `serr_n` pulse and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Address phase of a new master transfer |
| xfer_done | input | 1 | Transfer completed successfully |
| tgt_retry | input | 1 | Target signalled a retry |
| devsel_seen | input | 1 | DEVSEL sampled active on this clock |
| self_sel | input | 1 | The claiming target is this device |
| gnt | input | 1 | Bus grant |
| retry_limit | input | 4 | Largest retry count tolerated |
| err_clear | input | 1 | Software clear of the abort flag |
| serr_n | output | 1 | System error pulse, active low |
| abort_flag | output | 1 | Sticky master-abort indication |
| hold_req | output | 1 | Keep requesting the bus for one cell |

## Verification
The checker assumes that the engine never raises `xfer_done` and `tgt_retry` on the same clock. It also assumes the engine starts a transfer only from idle, and that `err_clear` is not raised on the clock that would set an abort. The bench drives each of these events as a single-cycle pulse on its own cycle, always after the previous transfer has reached idle. The grant is raised only after the previous hold window has ended, so the hold-length check always observes one complete window.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
    typedef enum logic [1:0] {
        MS_IDLE    = 2'd0,
        MS_SEEK    = 2'd1,
        MS_CLAIMED = 2'd2
    } mstate_t;
endpackage

// File: rtl/busmon_selwin.sv
// Claim-window counter: counts DEVSEL samples after the address phase.
module busmon_selwin #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    output logic last
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIN - 1);

    logic [CW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx <= '0;
        else if (arm)    idx <= '0;
        else if (active) idx <= (idx == LAST_IDX) ? idx : idx + 1'b1;
    end

    assign last = active && (idx == LAST_IDX);
endmodule

// File: rtl/busmon_retry.sv
// Saturating retry counter with limit-crossing detect.
module busmon_retry #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             wipe,
    input  logic [LIM_W-1:0] limit,
    output logic             crossed
);
    localparam int CW = LIM_W + 1;
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic [CW-1:0] lim_ext;

    assign lim_ext = {1'b0, limit};
    assign nxt     = (cnt == TOP) ? cnt : cnt + 1'b1;
    assign crossed = bump && (cnt <= lim_ext) && (nxt > lim_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (wipe) cnt <= '0;
        else if (bump) cnt <= nxt;
    end
endmodule

// File: rtl/busmon_hold.sv
// Minimum-tenure timer started by a rising grant.
module busmon_hold #(
    parameter int CELL_BYTES = 48,
    parameter int WORD_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    output logic hold
);
    localparam int HOLD_CYC = CELL_BYTES / WORD_BYTES;
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] left;
    logic          gnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left  <= '0;
            gnt_q <= 1'b0;
        end else begin
            gnt_q <= gnt;
            if (gnt && !gnt_q)   left <= HW'(HOLD_CYC);
            else if (left != '0) left <= left - 1'b1;
        end
    end

    assign hold = (left != '0);
endmodule

// File: rtl/busmon_top.sv
module busmon_top
    import busmon_pkg::*;
#(
    parameter int LIM_W      = 4,
    parameter int SEL_WIN    = 4,
    parameter int CELL_BYTES = 48,
    parameter int WORD_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_done,
    input  logic             tgt_retry,
    input  logic             devsel_seen,
    input  logic             self_sel,
    input  logic             gnt,
    input  logic [LIM_W-1:0] retry_limit,
    input  logic             err_clear,
    output logic             serr_n,
    output logic             abort_flag,
    output logic             hold_req
);
    mstate_t state, state_nxt;
    logic    win_last;
    logic    crossed;
    logic    in_seek, in_claim;
    logic    self_hit, timeout;

    assign in_seek  = (state == MS_SEEK);
    assign in_claim = (state == MS_CLAIMED);
    assign self_hit = in_seek && devsel_seen && self_sel;
    assign timeout  = win_last && !devsel_seen;

    busmon_selwin #(.WIN(SEL_WIN)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (state == MS_IDLE && xfer_start),
        .active (in_seek),
        .last   (win_last)
    );

    busmon_retry #(.LIM_W(LIM_W)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump    (in_claim && tgt_retry),
        .wipe    (in_claim && xfer_done && !tgt_retry),
        .limit   (retry_limit),
        .crossed (crossed)
    );

    busmon_hold #(.CELL_BYTES(CELL_BYTES), .WORD_BYTES(WORD_BYTES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (gnt),
        .hold  (hold_req)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MS_IDLE;
        else        state <= state_nxt;
    end

    // Next state: launch, claim, timeout, retried, finished
    always_comb begin
        state_nxt = state;
        unique case (state)
            MS_IDLE:    if (xfer_start) state_nxt = MS_SEEK;
            MS_SEEK: begin
                if (devsel_seen)  state_nxt = MS_CLAIMED;
                else if (timeout) state_nxt = MS_IDLE;
            end
            MS_CLAIMED: if (tgt_retry || xfer_done) state_nxt = MS_IDLE;
            default:    state_nxt = MS_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serr_n     <= 1'b1;
            abort_flag <= 1'b0;
        end else begin
            serr_n <= !(crossed || self_hit);
            if (in_seek && timeout) abort_flag <= 1'b1;
            else if (err_clear)     abort_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/busmon_chk.sv
module busmon_chk #(
    parameter int CELL_BYTES = 48,
    parameter int WORD_BYTES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tgt_retry,
    input logic devsel_seen,
    input logic self_sel,
    input logic gnt,
    input logic err_clear,
    input logic serr_n,
    input logic abort_flag,
    input logic hold_req
);
    localparam int HOLD_CYC = CELL_BYTES / WORD_BYTES;
    localparam int HW = $clog2(HOLD_CYC + 2);

    logic [HW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run <= '0;
        else if (hold_req) run <= (run == '1) ? run : run + 1'b1;
        else               run <= '0;
    end

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag && !err_clear |=> abort_flag); // R4
    AST_ABORT_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> !$past(devsel_seen)); // R3
    AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(tgt_retry || (devsel_seen && self_sel))); // R5
    AST_HOLD_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt) |=> hold_req); // R9
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run <= HW'(HOLD_CYC)); // R9
endmodule

bind busmon_top busmon_chk #(.CELL_BYTES(CELL_BYTES), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_retry   (tgt_retry),
    .devsel_seen (devsel_seen),
    .self_sel    (self_sel),
    .gnt         (gnt),
    .err_clear   (err_clear),
    .serr_n      (serr_n),
    .abort_flag  (abort_flag),
    .hold_req    (hold_req)
);

// File: tb/tb_busmon_top.sv
`timescale 1ns/1ps
module tb_busmon_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 0, xfer_done = 0, tgt_retry = 0, devsel_seen = 0;
    logic self_sel = 0, gnt = 0, err_clear = 0;
    logic [3:0] retry_limit = 4'd1;
    logic serr_n, abort_flag, hold_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    busmon_top dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .tgt_retry(tgt_retry), .devsel_seen(devsel_seen), .self_sel(self_sel),
        .gnt(gnt), .retry_limit(retry_limit), .err_clear(err_clear),
        .serr_n(serr_n), .abort_flag(abort_flag), .hold_req(hold_req)
    );

    // Vector: {start,devsel,self,retry,done,gnt,clear, exp_serr_n,exp_abort,exp_hold}
    localparam int NV = 24;
    localparam logic [9:0] VEC [NV] = '{
        10'b1000000_100, // 0 launch
        10'b0100000_100, // 1 claim
        10'b0001000_100, // 2 retry 1, limit 1: quiet
        10'b1000000_100, // 3
        10'b0100000_100, // 4
        10'b0001000_000, // 5 retry 2 crosses limit: R5
        10'b0000000_100, // 6 one-clock pulse
        10'b1000000_100, // 7
        10'b0100000_100, // 8
        10'b0000100_100, // 9 done clears count: R6
        10'b1000000_100, // 10
        10'b0100000_100, // 11
        10'b0001000_100, // 12 retry 1 after clear: R6
        10'b1000000_100, // 13 launch, nobody claims
        10'b0000000_100, // 14 sample 1
        10'b0000000_100, // 15 sample 2
        10'b0000000_100, // 16 sample 3
        10'b0000000_110, // 17 sample 4: abort R3
        10'b0000000_110, // 18 sticky R4
        10'b0000001_100, // 19 clear R4
        10'b1000000_100, // 20
        10'b0110000_000, // 21 self claim R8
        10'b0000100_100, // 22 done
        10'b0000010_101  // 23 grant rise R9
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [6:0] s);
        {xfer_start, devsel_seen, self_sel, tgt_retry, xfer_done, gnt, err_clear} = s;
        tick();
    endtask

    // One claimed transfer ending in a retry; returns serr_n after the retry edge
    task automatic one_retry(output logic sn);
        drive(7'b1000000);
        drive(7'b0100000);
        drive(7'b0001000);
        sn = serr_n;
        drive(7'b0000000);
    endtask

    task automatic finish_ok();
        drive(7'b1000000);
        drive(7'b0100000);
        drive(7'b0000100);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic sn;
        int pulses;
        int hcnt;
        repeat (3) @(negedge clk);
        chk("R1 serr_n", serr_n, 1'b1);
        chk("R1 abort_flag", abort_flag, 1'b0);
        chk("R1 hold_req", hold_req, 1'b0);
        rst_n = 1'b1;
        tick();

        // Table walk, limit 1
        retry_limit = 4'd1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][9:3]);
            chk($sformatf("R5/R3/R4/R8/R9 vec%0d serr_n", i), serr_n, VEC[i][2]);
            chk($sformatf("R3/R4 vec%0d abort", i), abort_flag, VEC[i][1]);
            chk($sformatf("R9 vec%0d hold", i), hold_req, VEC[i][0]);
        end

        // R9: hold lasts 12 clocks in total while gnt stays high
        hcnt = 1;
        for (int k = 0; k < 20; k++) begin
            drive(7'b0000010);
            if (hold_req) hcnt++;
        end
        chk("R9 hold length is 12", 1'(hcnt == 12), 1'b1);
        chk("R9 hold drops with gnt high", hold_req, 1'b0);
        drive(7'b0000000);

        // R2: claim on the 4th sample, no abort
        drive(7'b1000000);
        drive(7'b0000000);
        drive(7'b0000000);
        drive(7'b0000000);
        drive(7'b0100000);
        chk("R2 late claim no abort", abort_flag, 1'b0);
        drive(7'b0000100);
        chk("R2 still no abort", abort_flag, 1'b0);

        // R5: limit 15, the 16th retry fires
        retry_limit = 4'd15;
        for (int k = 1; k <= 16; k++) begin
            one_retry(sn);
            if (k < 16) begin
                if (sn !== 1'b1) chk($sformatf("R5 limit15 retry %0d quiet", k), sn, 1'b1);
            end else begin
                chk("R5 limit15 retry 16 fires", sn, 1'b0);
            end
        end
        finish_ok();

        // R10: retry while idle is ignored
        retry_limit = 4'd0;
        drive(7'b0001000);
        chk("R10 idle retry no serr", serr_n, 1'b1);
        drive(7'b0000000);
        one_retry(sn);
        chk("R10 count untouched, first claimed retry fires at limit 0", sn, 1'b0);
        finish_ok();

        // R7: saturation, 40 retries at limit 0 give exactly one pulse
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            one_retry(sn);
            if (sn == 1'b0) pulses++;
        end
        chk("R7 single pulse over 40 retries", 1'(pulses == 1), 1'b1);
        finish_ok();
        chk("R6 done returns to quiet", serr_n, 1'b1);

        done_flag = 1;
        report();
    end
endmodule